// File: doc/BRIEF.md
# Audio Codec Power-Down Controller

This block is the power-management logic of an audio codec that talks to its controller over a serial link. It holds one control and status register at index 26h, which a controller writes and reads over a simple register bus. Eight command bits sit in the upper byte. They are decoded combinationally into enables for the ADC, DAC, mixer, voltage reference, line-level output, external amplifier, internal clock and link interface. One command bit overrides all the analog sections at once. Two command bits put the codec to sleep.

Each of the ADC, DAC, mixer (analog) and reference sections has a read-only ready flag. The flag rises only after a programmable number of cycles of continuous enable, and it drops at once when the section is switched off. The ready flags gate the slot-valid tags that frame logic places in slot 0. While asleep, the register ignores writes and keeps its contents. A pulse on the sync input wakes the codec by clearing only the two sleep bits. The asynchronous reset input is the cold reset and returns everything to its defaults.

Top module: `codec_pd_ctrl`

## Requirements
- R1: After cold reset, every command bit reads 0, every section enable output is 1, every ready flag reads 0 and both slot-valid outputs are 0.
- R2: The register answers only at bus index 26h, with command bits PR7..PR0 at data bits 15..8 and ready flags at bits 3..0 (bit 0 ADC, bit 1 DAC, bit 2 analog mixer, bit 3 reference). Bits 7..4 read 0. Reads at any other index return 0, and writes there change nothing.
- R3: While PR3 is 1, the ADC, DAC, mixer, reference and line-output enables are 0 whatever the other bits hold. When PR3 is cleared, each section follows its own bit again.
- R4: PR0 switches off the ADC and PR1 the DAC. PR2 switches off the mixer and the line output, which removes the DAC output path. PR6 switches off the line output and PR7 the external amplifier.
- R5: PR4 switches off the ADC, the DAC and the link interface.
- R6: PR5 switches off the ADC, the DAC, the line output and the link interface, and drives the clock-run output to 0.
- R7: While PR4 or PR5 is 1, register writes are ignored and all register contents are kept.
- R8: A sync pulse while PR4 or PR5 is 1 clears both bits on the next clock edge and leaves the other six command bits unchanged. A sync pulse while awake has no effect.
- R9: A ready flag becomes 1 exactly SETTLE_CYC clock edges after its section enable rises. It stays 1 while the section is enabled and reads 0 in the same cycle the enable falls.
- R10: The ADC slot-valid output equals the ADC ready flag. The DAC slot-valid output is 1 only when both the DAC and mixer ready flags are 1.
- R11: Data written to bits 3..0 is ignored; those bits always report the ready flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed index |
| sync_pulse | input | 1 | Sync line level, a high cycle wakes a sleeping codec |
| en_adc | output | 1 | ADC section enable |
| en_dac | output | 1 | DAC section enable |
| en_mixer | output | 1 | Mixer section enable |
| en_vref | output | 1 | Reference enable |
| en_lineout | output | 1 | Line-level output enable |
| en_extamp | output | 1 | External amplifier enable |
| clk_run | output | 1 | Internal clock run request |
| link_on | output | 1 | Link interface enable |
| slot_ok_adc | output | 1 | Slot-valid qualifier for ADC slots |
| slot_ok_dac | output | 1 | Slot-valid qualifier for DAC slots |

## Verification
The assertions assume that bus_we, bus_addr, bus_wdata and sync_pulse change only between clock edges and hold a defined value at each rising edge. They also assume that a wake pulse on sync_pulse is one or more whole cycles wide. The bench drives every input on the falling edge and holds it for whole cycles, so it stays within these assumptions. A wake pulse and a blocked write may land in the same cycle; the properties describe this case as the wake taking effect and the write being dropped. A sync pulse while awake is therefore legal stimulus, not a violation.

// File: rtl/codec_pd_pkg.sv
package codec_pd_pkg;

  // positions in the decoded enable vector
  localparam int EN_ADC  = 0;
  localparam int EN_DAC  = 1;
  localparam int EN_MIX  = 2;
  localparam int EN_VREF = 3;
  localparam int EN_LINE = 4;
  localparam int EN_AMP  = 5;
  localparam int EN_CLK  = 6;
  localparam int EN_LINK = 7;
  localparam int N_EN    = 8;

  // number of sections reporting a ready flag
  localparam int N_RDY = 4;

  // command bits to enables; a 1 in cmd asks for power-down
  function automatic logic [N_EN-1:0] pd_decode(input logic [7:0] cmd);
    logic [N_EN-1:0] e;
    logic all_off;
    all_off     = cmd[3];
    e[EN_ADC]   = !(cmd[0] || all_off || cmd[4] || cmd[5]);
    e[EN_DAC]   = !(cmd[1] || all_off || cmd[4] || cmd[5]);
    e[EN_MIX]   = !(cmd[2] || all_off);
    e[EN_VREF]  = !all_off;
    e[EN_LINE]  = !(cmd[2] || all_off || cmd[5] || cmd[6]);
    e[EN_AMP]   = !cmd[7];
    e[EN_CLK]   = !cmd[5];
    e[EN_LINK]  = !(cmd[4] || cmd[5]);
    return e;
  endfunction

  // sleep state held by the two sleep bits
  function automatic logic pd_sleeping(input logic [7:0] cmd);
    return cmd[4] || cmd[5];
  endfunction

endpackage

// File: rtl/codec_pd_settle.sv
module codec_pd_settle #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_en,
  output logic sec_ready
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!sec_en)      cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  // drops in the same cycle as the enable
  assign sec_ready = sec_en && (cnt == LIMIT);
endmodule

// File: rtl/codec_pd_cmdreg.sv
module codec_pd_cmdreg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [7:0] wr_cmd,
  input  logic       sync_pulse,
  output logic [7:0] cmd,
  output logic       sleep_st,
  output logic       wake_evt,
  output logic       wr_take
);
  import codec_pd_pkg::*;

  localparam logic [7:0] SLEEP_CLR = 8'hCF;

  assign sleep_st = pd_sleeping(cmd);
  assign wake_evt = sleep_st && sync_pulse;
  assign wr_take  = wr_hit && !sleep_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmd <= '0;
    else if (wake_evt) cmd <= cmd & SLEEP_CLR;
    else if (wr_take)  cmd <= wr_cmd;
  end
endmodule

// File: rtl/codec_pd_ctrl.sv
module codec_pd_ctrl #(
  parameter int              ADDR_W     = 7,
  parameter int              DATA_W     = 16,
  parameter logic [ADDR_W-1:0] REG_IDX  = 7'h26,
  parameter int              SETTLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sync_pulse,
  output logic              en_adc,
  output logic              en_dac,
  output logic              en_mixer,
  output logic              en_vref,
  output logic              en_lineout,
  output logic              en_extamp,
  output logic              clk_run,
  output logic              link_on,
  output logic              slot_ok_adc,
  output logic              slot_ok_dac
);
  import codec_pd_pkg::*;

  localparam int CMD_LSB = DATA_W - 8;
  localparam int GAP_W   = CMD_LSB - N_RDY;

  logic              addr_hit;
  logic              wr_hit;
  logic [7:0]        cmd;
  logic              sleep_st;
  logic              wake_evt;
  logic              wr_take;
  logic [N_EN-1:0]   en_vec;
  logic [N_RDY-1:0]  sec_en;
  logic [N_RDY-1:0]  rdy;

  assign addr_hit = (bus_addr == REG_IDX);
  assign wr_hit   = bus_we && addr_hit;

  codec_pd_cmdreg u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hit     (wr_hit),
    .wr_cmd     (bus_wdata[DATA_W-1:CMD_LSB]),
    .sync_pulse (sync_pulse),
    .cmd        (cmd),
    .sleep_st   (sleep_st),
    .wake_evt   (wake_evt),
    .wr_take    (wr_take)
  );

  assign en_vec = pd_decode(cmd);

  assign en_adc     = en_vec[EN_ADC];
  assign en_dac     = en_vec[EN_DAC];
  assign en_mixer   = en_vec[EN_MIX];
  assign en_vref    = en_vec[EN_VREF];
  assign en_lineout = en_vec[EN_LINE];
  assign en_extamp  = en_vec[EN_AMP];
  assign clk_run    = en_vec[EN_CLK];
  assign link_on    = en_vec[EN_LINK];

  // ready flag order: ADC, DAC, analog mixer, reference
  assign sec_en = {en_vec[EN_VREF], en_vec[EN_MIX], en_vec[EN_DAC], en_vec[EN_ADC]};

  for (genvar g = 0; g < N_RDY; g++) begin : g_settle
    codec_pd_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .sec_en    (sec_en[g]),
      .sec_ready (rdy[g])
    );
  end

  assign slot_ok_adc = rdy[0];
  assign slot_ok_dac = rdy[1] && rdy[2];

  assign bus_rdata = addr_hit ? {cmd, {GAP_W{1'b0}}, rdy} : '0;
endmodule

// File: rtl/codec_pd_ctrl_chk.sv
module codec_pd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cmd,
  input logic       sleep_st,
  input logic       wake_evt,
  input logic       sync_pulse,
  input logic [3:0] rdy,
  input logic       en_adc,
  input logic       en_dac,
  input logic       en_mixer,
  input logic       en_vref,
  input logic       en_lineout,
  input logic       clk_run,
  input logic       link_on,
  input logic       slot_ok_dac
);
  // R3: the override bit silences every analog section
  a_r3_override: assert property (@(posedge clk) disable iff (!rst_n)
    cmd[3] |-> !en_adc && !en_dac && !en_mixer && !en_vref && !en_lineout);

  // R6: the clock-stop sleep bit stops the clock and the link
  a_r6_clock_stop: assert property (@(posedge clk) disable iff (!rst_n)
    cmd[5] |-> !clk_run && !link_on);

  // R7: asleep and no wake: contents frozen
  a_r7_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_st && !sync_pulse) |=> $stable(cmd));

  // R8: wake clears only the two sleep bits
  a_r8_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !cmd[4] && !cmd[5]);

  a_r8_wake_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (cmd[7:6] == $past(cmd[7:6])) && (cmd[3:0] == $past(cmd[3:0])));

  // R9: ready never shown for a disabled section
  a_r9_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !en_adc |-> !rdy[0]);

  // R9: a ready flag rises only after the section was already on
  a_r9_ready_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy[1]) |-> $past(en_dac) && en_dac);

  // R10: DAC slots need DAC and mixer on
  a_r10_dac_slot: assert property (@(posedge clk) disable iff (!rst_n)
    slot_ok_dac |-> en_dac && en_mixer);
endmodule

bind codec_pd_ctrl codec_pd_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd         (cmd),
  .sleep_st    (sleep_st),
  .wake_evt    (wake_evt),
  .sync_pulse  (sync_pulse),
  .rdy         (rdy),
  .en_adc      (en_adc),
  .en_dac      (en_dac),
  .en_mixer    (en_mixer),
  .en_vref     (en_vref),
  .en_lineout  (en_lineout),
  .clk_run     (clk_run),
  .link_on     (link_on),
  .slot_ok_dac (slot_ok_dac)
);

// File: tb/codec_pd_ctrl_tb.sv
module codec_pd_ctrl_tb;
  localparam int CLK_P  = 10;
  localparam int SETTLE = 6;
  localparam logic [6:0] IDX = 7'h26;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_we = 0;
  logic [6:0]  bus_addr = IDX;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        sync_pulse = 0;
  logic en_adc, en_dac, en_mixer, en_vref, en_lineout, en_extamp, clk_run, link_on;
  logic slot_ok_adc, slot_ok_dac;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  codec_pd_ctrl #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_pulse(sync_pulse),
    .en_adc(en_adc), .en_dac(en_dac), .en_mixer(en_mixer), .en_vref(en_vref),
    .en_lineout(en_lineout), .en_extamp(en_extamp), .clk_run(clk_run),
    .link_on(link_on), .slot_ok_adc(slot_ok_adc), .slot_ok_dac(slot_ok_dac)
  );

  // bench view of enables: {link,clk,amp,line,vref,mix,dac,adc}
  logic [7:0] en_obs;
  assign en_obs = {link_on, clk_run, en_extamp, en_lineout, en_vref, en_mixer, en_dac, en_adc};

  // {command byte, expected enables}
  localparam logic [15:0] VEC [12] = '{
    16'h00FF, 16'h01FE, 16'h02FD, 16'h04EB, 16'h08E0, 16'h107C,
    16'h202C, 16'h40EF, 16'h80DF, 16'h09E0, 16'h06E9, 16'hC0CF
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_addr = IDX;
    #1;
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    sync_pulse = 1;
    @(negedge clk);
    sync_pulse = 0;
    #1;
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 rdata", {16'h0, bus_rdata}, 32'h0);
    chk("R1 enables", {24'h0, en_obs}, 32'hFF);
    chk("R1 slots", {30'h0, slot_ok_adc, slot_ok_dac}, 32'h0);
    // R9 settle from reset
    wait_cyc(SETTLE - 1);
    chk("R9 not yet ready", {16'h0, bus_rdata}, 32'h0);
    wait_cyc(1);
    chk("R9 ready after settle", {16'h0, bus_rdata}, 32'h000F);
    chk("R10 slots on", {30'h0, slot_ok_adc, slot_ok_dac}, 32'h3);

    // decode table for R3 R4 R5 R6
    for (int i = 0; i < 12; i++) begin
      wr(IDX, {VEC[i][15:8], 8'h00});
      chk("R3/R4/R5/R6 decode", {24'h0, en_obs}, {24'h0, VEC[i][7:0]});
      chk("R2 command readback", {24'h0, bus_rdata[15:8]}, {24'h0, VEC[i][15:8]});
      pulse_sync();
      wr(IDX, 16'h0000);
    end

    wait_cyc(SETTLE + 1);
    chk("R9 all settled", {16'h0, bus_rdata}, 32'h000F);

    // R11 status nibble not writable
    wr(IDX, 16'h010F);
    chk("R11 status ignores write", {16'h0, bus_rdata}, 32'h010E);
    chk("R10 adc slot off dac slot on", {30'h0, slot_ok_adc, slot_ok_dac}, 32'h1);

    // R9 exact settle count
    wr(IDX, 16'h0000);
    wait_cyc(SETTLE - 1);
    chk("R9 adc one short", {16'h0, bus_rdata}, 32'h000E);
    wait_cyc(1);
    chk("R9 adc ready", {16'h0, bus_rdata}, 32'h000F);

    // R10 mixer gates DAC slots
    wr(IDX, 16'h0400);
    chk("R10 mixer off status", {16'h0, bus_rdata}, 32'h040B);
    chk("R10 dac slot gated", {31'h0, slot_ok_dac}, 32'h0);
    chk("R10 adc slot kept", {31'h0, slot_ok_adc}, 32'h1);
    wr(IDX, 16'h0000);
    wait_cyc(SETTLE);

    // R3 restore per own bit
    wr(IDX, 16'h0900);
    chk("R3 override", {24'h0, en_obs}, 32'hE0);
    wr(IDX, 16'h0100);
    chk("R3 restored enables", {24'h0, en_obs}, 32'hFE);
    chk("R3 restored status low", {16'h0, bus_rdata}, 32'h0100);
    wait_cyc(SETTLE);
    chk("R3 restored settled", {16'h0, bus_rdata}, 32'h010E);

    // R2 other index
    wr(7'h27, 16'hFF00);
    chk("R2 foreign write", {16'h0, bus_rdata}, 32'h010E);
    @(negedge clk); bus_addr = 7'h27; #1;
    chk("R2 foreign read", {16'h0, bus_rdata}, 32'h0);
    bus_addr = IDX; #1;

    // R7 sleep blocks writes
    wr(IDX, 16'h1000);
    wr(IDX, 16'h8000);
    chk("R7 write blocked", {16'h0, bus_rdata}, 32'h100C);
    chk("R5 link off", {31'h0, link_on}, 32'h0);

    // R8 wake
    pulse_sync();
    chk("R8 wake clears", {16'h0, bus_rdata}, 32'h000C);
    chk("R8 link back", {31'h0, link_on}, 32'h1);
    wr(IDX, 16'h5100);
    pulse_sync();
    chk("R8 other bits kept", {24'h0, bus_rdata[15:8]}, 32'h41);
    pulse_sync();
    chk("R8 awake sync no effect", {24'h0, bus_rdata[15:8]}, 32'h41);
    wr(IDX, 16'h3000);
    chk("R6 clock stopped", {30'h0, clk_run, link_on}, 32'h0);
    pulse_sync();
    chk("R8 both sleep bits cleared", {24'h0, bus_rdata[15:8]}, 32'h00);
    chk("R6 clock resumed", {31'h0, clk_run}, 32'h1);

    // R1 cold reset after activity
    wr(IDX, 16'hC100);
    @(negedge clk); rst_n = 0; #1;
    chk("R1 cold reset", {16'h0, bus_rdata}, 32'h0);
    @(negedge clk); rst_n = 1; #1;
    chk("R1 enables after cold reset", {24'h0, en_obs}, 32'hFF);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule